// File: doc/BRIEF.md
# Automatic UART Bit-Rate Detector

This block finds the bit rate of a host that repeatedly sends the byte 0x00 on a serial line. Every such frame holds the line low for nine bit times: the start bit and eight zero data bits. The block times that low run in system clocks, two frames in a row. When the two runs agree, it works out the divisor a 16x-oversampling UART needs and presents it with a one-cycle write strobe.

It then sends one 0x00 frame back on its own transmit pin at the learned rate, to tell the host that adjustment is finished. After that it sets a done flag and ignores the line until the next reset.

Runs that are too short are treated as noise. Runs that overflow the counter, and pairs that disagree, raise a one-cycle error pulse, and detection then goes on by itself.

Top module: `baud_autodetect`

## Requirements
- R1: While reset is held and right after it, `tx_o` is 1 and `done_o`, `err_o`, `div_wr_o` and `div_o` are all 0.
- R2: A low run is measured as the number of clock cycles `rx_i` stays 0. A run shorter than 16 cycles is ignored: it raises no error and does not take part in any comparison.
- R3: Two accepted runs in a row, C1 then C2, agree when |C2 - C1| <= C1 >> 5. If they disagree, `err_o` pulses for one cycle, C2 becomes the new reference, and no divisor is written.
- R4: When the runs agree, `div_o` takes the value floor((C1 + C2 + 144) / 288) - 1, clamped at 0. This is the nearest divisor for a bit period of C/9 clocks at 16x oversampling. It is written with a one-cycle `div_wr_o` pulse.
- R5: A run that stays low for more than 2^CNT_W - 1 cycles raises one `err_o` pulse and is discarded, and two new runs are needed. A run of exactly 2^CNT_W - 1 cycles is still valid.
- R6: After the divisor is written, `tx_o` stays low for exactly 9*(div+1)*16 cycles and then high for (div+1)*16 cycles. `done_o` rises at the end of that high stop bit.
- R7: Once `done_o` is 1, it stays 1, `div_o` holds its value, and activity on `rx_i` causes no `err_o` and no `div_wr_o`.
- R8: `div_wr_o` is high in the fourth cycle after the clock edge that first samples `rx_i` high at the end of the second agreeing run. `tx_o` falls one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Raw serial receive line from the host |
| tx_o | output | 1 | Serial line carrying the 0x00 acknowledgment frame |
| div_o | output | DIV_W | Learned UART divisor |
| div_wr_o | output | 1 | One-cycle strobe that loads `div_o` into the UART |
| done_o | output | 1 | Adjustment finished and acknowledgment sent |
| err_o | output | 1 | One-cycle pulse on counter overflow or on disagreeing runs |

## Verification
The receive path has a two-stage synchronizer, an edge register, a registered measurement and a registered decision. The divisor strobe therefore lands exactly four edges after the edge that sees the line return high. The bench samples `div_wr_o` at the falling clock edge after edge three, where it must still be low, and again after edge four, where it must be high. The acknowledgment frame starts one edge later. The bench counts falling-edge samples of `tx_o` low and of the stop bit before `done_o`, and compares those counts with 9P and P, where P is (div+1)*16. Error and strobe pulses are counted at every falling edge, so a pulse that is missing or repeated shows up whichever cycle it lands in.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Line stays low for start bit plus eight zero data bits.
  localparam int unsigned LOW_BITS = 9;
  // Start, eight data, stop.
  localparam int unsigned ACK_BITS = 10;

  typedef enum logic [1:0] {
    ST_REF  = 2'd0,
    ST_CMP  = 2'd1,
    ST_ACK  = 2'd2,
    ST_DONE = 2'd3
  } ctrl_state_t;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  // chain_q[STAGES-1] is the synchronized level; chain_q[STAGES] is one cycle older.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], rx_i};
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
  assign rise_o = ~chain_q[STAGES] & chain_q[STAGES-1];
endmodule

// File: rtl/lowrun_meter.sv
module lowrun_meter #(
  parameter int CNT_W      = 20,
  parameter int GLITCH_MIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W-1:0] RUN_MIN = CNT_W'(GLITCH_MIN);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic             vld_q, vld_d;
  logic             sat_q, sat_d;
  logic [CNT_W-1:0] res_q;
  logic             res_en;

  always_comb begin
    busy_d = busy_q;
    run_d  = run_q;
    vld_d  = 1'b0;
    sat_d  = 1'b0;
    if (fall_i) begin
      busy_d = 1'b1;
      run_d  = CNT_W'(1);
    end else if (busy_q) begin
      if (rise_i) begin
        busy_d = 1'b0;
        vld_d  = (run_q >= RUN_MIN);
      end else if (!lvl_i) begin
        if (run_q == RUN_MAX) begin
          busy_d = 1'b0;
          sat_d  = 1'b1;
        end else begin
          run_d = run_q + CNT_W'(1);
        end
      end
    end
  end

  assign res_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      run_q  <= '0;
      vld_q  <= 1'b0;
      sat_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      run_q  <= run_d;
      vld_q  <= vld_d;
      sat_q  <= sat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= run_q;
  end

  assign vld_o = vld_q;
  assign cnt_o = res_q;
  assign sat_o = sat_q;
endmodule

// File: rtl/rate_judge.sv
module rate_judge #(
  parameter int CNT_W     = 20,
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int TOL_SHIFT = 5
) (
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] cur_i,
  output logic             agree_o,
  output logic [DIV_W-1:0] div_o
);
  import baud_pkg::*;

  localparam int unsigned NUM_W = CNT_W + 2;
  localparam int unsigned DEN   = LOW_BITS * OVS;
  localparam logic [NUM_W-1:0] HALF_SPAN = NUM_W'(DEN);
  localparam logic [NUM_W-1:0] FULL_SPAN = NUM_W'(2 * DEN);

  logic [CNT_W-1:0] diff;
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] quot;

  always_comb begin
    diff    = (ref_i >= cur_i) ? (ref_i - cur_i) : (cur_i - ref_i);
    agree_o = (diff <= (ref_i >> TOL_SHIFT));
    // Average of two runs, rounded to whole divisor steps.
    num     = {2'b00, ref_i} + {2'b00, cur_i} + HALF_SPAN;
    quot    = num / FULL_SPAN;
    div_o   = (quot == '0) ? '0 : DIV_W'(quot - NUM_W'(1));
  end
endmodule

// File: rtl/ack_sender.sv
module ack_sender #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tx_o,
  output logic             fin_o
);
  import baud_pkg::*;

  localparam int PER_W = DIV_W + $clog2(OVS) + 1;
  localparam logic [3:0] LAST_BIT = 4'(ACK_BITS - 1);

  logic             busy_q, busy_d;
  logic [3:0]       bit_q, bit_d;
  logic [PER_W-1:0] tick_q, tick_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] per_c;
  logic             bit_end;

  assign per_c   = (PER_W'(div_i) + PER_W'(1)) * PER_W'(OVS);
  assign bit_end = (tick_q == per_q - PER_W'(1));

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    tick_d = tick_q;
    per_d  = per_q;
    fin_o  = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      bit_d  = '0;
      tick_d = '0;
      per_d  = per_c;
    end else if (busy_q) begin
      if (bit_end) begin
        tick_d = '0;
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          fin_o  = 1'b1;
        end else begin
          bit_d = bit_q + 4'd1;
        end
      end else begin
        tick_d = tick_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      tick_q <= '0;
      per_q  <= PER_W'(OVS);
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      tick_q <= tick_d;
      per_q  <= per_d;
    end
  end

  // Every bit of the 0x00 frame is low except the final stop bit.
  assign tx_o = ~busy_q | (bit_q == LAST_BIT);
endmodule

// File: rtl/baud_autodetect.sv
module baud_autodetect #(
  parameter int CNT_W       = 20,
  parameter int DIV_W       = 16,
  parameter int OVS         = 16,
  parameter int GLITCH_MIN  = 16,
  parameter int TOL_SHIFT   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [DIV_W-1:0] div_o,
  output logic             div_wr_o,
  output logic             done_o,
  output logic             err_o
);
  import baud_pkg::*;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic             lvl, fall, rise;
  logic             meas_vld, meas_sat;
  logic [CNT_W-1:0] meas_cnt;
  logic             agree;
  logic [DIV_W-1:0] div_calc;
  logic             tx_fin;

  rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .rx_i(rx_i),
    .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  lowrun_meter #(.CNT_W(CNT_W), .GLITCH_MIN(GLITCH_MIN)) u_meter (
    .clk(clk), .rst_n(srst_n), .lvl_i(lvl), .fall_i(fall), .rise_i(rise),
    .vld_o(meas_vld), .cnt_o(meas_cnt), .sat_o(meas_sat)
  );

  ctrl_state_t      state_q, state_d;
  logic [CNT_W-1:0] ref_q, ref_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_q, wr_d;
  logic             err_q, err_d;
  logic             start_q, start_d;
  logic             ref_en, div_en;

  rate_judge #(.CNT_W(CNT_W), .DIV_W(DIV_W), .OVS(OVS), .TOL_SHIFT(TOL_SHIFT)) u_judge (
    .ref_i(ref_q), .cur_i(meas_cnt), .agree_o(agree), .div_o(div_calc)
  );

  ack_sender #(.DIV_W(DIV_W), .OVS(OVS)) u_ack (
    .clk(clk), .rst_n(srst_n), .start_i(start_q), .div_i(div_q),
    .tx_o(tx_o), .fin_o(tx_fin)
  );

  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    div_d   = div_q;
    wr_d    = 1'b0;
    err_d   = 1'b0;
    start_d = 1'b0;
    unique case (state_q)
      ST_REF: begin
        if (meas_vld) begin
          ref_d   = meas_cnt;
          state_d = ST_CMP;
        end else if (meas_sat) begin
          err_d = 1'b1;
        end
      end
      ST_CMP: begin
        if (meas_vld) begin
          if (agree) begin
            div_d   = div_calc;
            wr_d    = 1'b1;
            start_d = 1'b1;
            state_d = ST_ACK;
          end else begin
            ref_d = meas_cnt;
            err_d = 1'b1;
          end
        end else if (meas_sat) begin
          err_d   = 1'b1;
          state_d = ST_REF;
        end
      end
      ST_ACK: begin
        if (tx_fin) state_d = ST_DONE;
      end
      default: ;
    endcase
  end

  assign ref_en = (ref_d != ref_q);
  assign div_en = wr_d;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_REF;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      err_q   <= err_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     ref_q <= '0;
    else if (ref_en) ref_q <= ref_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  assign div_o    = div_q;
  assign div_wr_o = wr_q;
  assign err_o    = err_q;
  assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/baud_autodetect_chk.sv
module baud_autodetect_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_o,
  input logic [DIV_W-1:0] div_o,
  input logic             div_wr_o,
  input logic             done_o,
  input logic             err_o
);
  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(div_o));

  // R7
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R7
  wr_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !div_wr_o);

  // R7
  err_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !err_o);

  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> tx_o);

  // R3
  wr_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_wr_o && err_o));

  // R8
  tx_idle_at_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_o |-> tx_o);
endmodule

bind baud_autodetect baud_autodetect_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .div_o(div_o),
  .div_wr_o(div_wr_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_baud_autodetect.sv
module tb_baud_autodetect;
  localparam int DIV_W = 16;
  localparam int CNT_W = 12;

  logic             clk;
  logic             rst_n;
  logic             rx;
  logic             tx_o;
  logic [DIV_W-1:0] div_o;
  logic             div_wr_o;
  logic             done_o;
  logic             err_o;

  int checks;
  int errors;
  int err_seen;
  int wr_seen;

  baud_autodetect #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx_o), .div_o(div_o),
    .div_wr_o(div_wr_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (err_o)    err_seen++;
    if (div_wr_o) wr_seen++;
  end

  typedef struct packed {
    int unsigned run1;
    int unsigned run2;
    int unsigned div;
  } vec_t;

  // Low-run pairs and the divisor R4 gives for them.
  localparam vec_t VT [7] = '{
    '{run1: 36,   run2: 36,   div: 0},
    '{run1: 144,  run2: 144,  div: 0},
    '{run1: 432,  run2: 432,  div: 2},
    '{run1: 900,  run2: 900,  div: 5},
    '{run1: 1440, run2: 1485, div: 9},
    '{run1: 2250, run2: 2250, div: 15},
    '{run1: 3906, run2: 3906, div: 26}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx    = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic send_run(input int lo, input int hi);
    rx = 1'b0;
    repeat (lo) @(posedge clk);
    #1 rx = 1'b1;
    repeat (hi) @(posedge clk);
    #1;
  endtask

  // Final agreeing run: checks strobe timing, divisor and the acknowledgment frame.
  task automatic final_run(input int lo, input int exp_div, input string tag);
    int per;
    int lowc;
    int highc;
    per = (exp_div + 1) * 16;
    rx = 1'b0;
    repeat (lo) @(posedge clk);
    #1 rx = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(div_wr_o == 1'b0, {"R8 early strobe ", tag}, int'(div_wr_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk(div_wr_o == 1'b1, {"R8 strobe cycle ", tag}, int'(div_wr_o), 1);
    chk(div_o == DIV_W'(exp_div), {"R4 divisor ", tag}, int'(div_o), exp_div);
    @(negedge clk);
    chk(tx_o == 1'b0, {"R8 tx start ", tag}, int'(tx_o), 0);
    lowc = 0;
    while (tx_o == 1'b0 && lowc < 100000) begin
      lowc++;
      @(negedge clk);
    end
    chk(lowc == 9 * per, {"R6 low span ", tag}, lowc, 9 * per);
    highc = 0;
    while (tx_o == 1'b1 && done_o == 1'b0 && highc < 100000) begin
      highc++;
      @(negedge clk);
    end
    chk(highc == per, {"R6 stop span ", tag}, highc, per);
    chk(done_o == 1'b1, {"R6 done ", tag}, int'(done_o), 1);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int e0;
    int w0;
    int d0;
    checks   = 0;
    errors   = 0;
    err_seen = 0;
    wr_seen  = 0;

    // R1 reset state
    rst_n = 1'b0;
    rx    = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tx_o == 1'b1 && done_o == 1'b0, "R1 in reset tx/done", int'({tx_o, done_o}), 2);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_o == 1'b1,      "R1 tx idle",   int'(tx_o), 1);
    chk(done_o == 1'b0,    "R1 done low",  int'(done_o), 0);
    chk(err_o == 1'b0,     "R1 err low",   int'(err_o), 0);
    chk(div_wr_o == 1'b0,  "R1 strobe low", int'(div_wr_o), 0);
    chk(div_o == '0,       "R1 divisor zero", int'(div_o), 0);

    // Vector table: two agreeing runs, then the acknowledgment.
    for (int i = 0; i < 7; i++) begin
      do_reset();
      e0 = err_seen;
      send_run(int'(VT[i].run1), 40);
      final_run(int'(VT[i].run2), int'(VT[i].div), $sformatf("vec%0d", i));
      chk(err_seen == e0, $sformatf("R3 no error vec%0d", i), err_seen - e0, 0);
    end

    // R2 glitches shorter than 16 are ignored.
    do_reset();
    e0 = err_seen;
    w0 = wr_seen;
    send_run(15, 40);
    send_run(900, 40);
    send_run(3, 40);
    chk(err_seen == e0 && wr_seen == w0, "R2 glitch ignored", err_seen - e0 + wr_seen - w0, 0);
    final_run(900, 5, "R2 after glitch");

    // R3 mismatch just past tolerance, then recovery.
    do_reset();
    e0 = err_seen;
    w0 = wr_seen;
    send_run(1440, 40);
    send_run(1486, 40);
    chk(err_seen - e0 == 1, "R3 mismatch error", err_seen - e0, 1);
    chk(wr_seen == w0, "R3 no strobe on mismatch", wr_seen - w0, 0);
    final_run(1486, 9, "R3 recovery");

    // R5 overflow discards the run.
    do_reset();
    e0 = err_seen;
    send_run(900, 40);
    send_run(5000, 40);
    chk(err_seen - e0 == 1, "R5 overflow error", err_seen - e0, 1);
    send_run(2250, 40);
    final_run(2250, 15, "R5 after overflow");

    // R5 run of exactly the counter maximum is valid.
    do_reset();
    e0 = err_seen;
    send_run(4095, 40);
    final_run(4095, 27, "R5 max run");
    chk(err_seen == e0, "R5 max run no error", err_seen - e0, 0);

    // R7 line ignored after done.
    e0 = err_seen;
    w0 = wr_seen;
    d0 = int'(div_o);
    send_run(900, 40);
    send_run(2000, 40);
    send_run(5000, 40);
    @(negedge clk);
    chk(div_o == DIV_W'(d0), "R7 divisor held", int'(div_o), d0);
    chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
    chk(err_seen == e0, "R7 no error", err_seen - e0, 0);
    chk(wr_seen == w0, "R7 no strobe", wr_seen - w0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule